// File: doc/BRIEF.md
# Dual Compare Timer

This block holds two independent 32-bit up-counters. Each counter has its own control word, a counter value that software can write, and a match value. Software reaches all of these through a small single-cycle register port. A write takes effect on the clock edge where the write enable is high. Read data is a combinational function of the address. While a channel's count-enable bit is set, its counter advances by one on every clock. There is no prescaler, so a divider setting of zero, meaning undivided, is the only rate.

When an enabled counter holds the same value as its match register, the channel's bit in a shared event register is set. That register is indexed by channel. Software clears a bit by writing a one to it. Each channel drives its own interrupt line. The line is high while the channel's event bit is set and its interrupt-enable bit is set.

For one-shot use, software first disables the channel. It then writes the counter, usually to zero, and the match value. Finally it sets both enable bits. The counter does not stop at the match. It keeps counting and wraps until software disables it.

The register port carries no streaming data, so it stays a plain address, write-enable and data interface with no valid/ready handshake and no back-pressure.

Top module: `dual_match_timer`

## Requirements
- R1: After reset every control word, counter, match value and event bit reads zero, and both interrupt lines are low.
- R2: While count-enable (control bit 0) is set, the counter increases by one on each clock. While that bit is clear, the counter holds its value.
- R3: A write to a counter register loads the written value on that edge. It takes priority over the increment.
- R4: If channel n's count-enable bit is set and its counter equals its match value at a clock edge, bit n of the event register is set after that edge. If software zeroes the counter, writes match value M and then enables the channel on edge E, the bit is first seen set after edge E+M+1.
- R5: Interrupt line n is high exactly when event bit n is set and channel n's interrupt-enable (control bit 1) is set.
- R6: The counter keeps counting past the match value and wraps from 0xFFFFFFFF to 0.
- R7: Writing the event register clears each bit that is written as 1 and leaves each bit written as 0 unchanged. Writing 0xFFFF clears every bit.
- R8: If a clearing write and a new match fall on the same edge, the event bit ends up set.
- R9: The channels are independent. Activity on one channel changes neither the counter nor the event bit of the other.
- R10: Register map: control words at 0x00 and 0x04, match at 0x18 and 0x1C, counters at 0x48 and 0x4C, event register at 0x60 with bit n for channel n. Control reads return bits [1:0] with all higher bits zero. Any other address reads zero.
- R11: An equal counter and match value does not set the event bit while count-enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Byte address of the register |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 2 | One interrupt line per channel |

## Verification
The hardest case to reach is a match and a clearing write landing on the same edge, because the match edge depends on the counter's running value. The stimulus zeroes the counter, writes a small match value, and enables the channel on a known edge. It then counts clocks so that the clearing write to the event register lands exactly on the compare edge. The wrap is reached quickly by preloading the counter two steps below its maximum.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int unsigned CTRL_BASE  = 32'h00;
  localparam int unsigned MATCH_BASE = 32'h18;
  localparam int unsigned COUNT_BASE = 32'h48;
  localparam int unsigned EVENT_ADDR = 32'h60;
  localparam int unsigned REG_STRIDE = 4;
  localparam int unsigned CTRL_W     = 2;
  localparam int unsigned CTRL_CE    = 0;
  localparam int unsigned CTRL_IE    = 1;
endpackage

// File: rtl/dmt_regdec.sv
module dmt_regdec
  import dmt_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ADDR_W-1:0]                addr,
  input  logic                             we,
  input  logic [NUM_CH-1:0][DATA_W-1:0]    ctrl_rd,
  input  logic [NUM_CH-1:0][DATA_W-1:0]    match_rd,
  input  logic [NUM_CH-1:0][DATA_W-1:0]    count_rd,
  input  logic [DATA_W-1:0]                event_rd,
  output logic [NUM_CH-1:0]                ctrl_we,
  output logic [NUM_CH-1:0]                match_we,
  output logic [NUM_CH-1:0]                count_we,
  output logic                             event_we,
  output logic [DATA_W-1:0]                rdata
);
  logic [NUM_CH-1:0] sel_ctrl, sel_match, sel_count;
  logic              sel_event;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_BASE  + REG_STRIDE * i);
    localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(MATCH_BASE + REG_STRIDE * i);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(COUNT_BASE + REG_STRIDE * i);
    assign sel_ctrl[i]  = (addr == A_CTRL);
    assign sel_match[i] = (addr == A_MATCH);
    assign sel_count[i] = (addr == A_COUNT);
  end

  assign sel_event = (addr == ADDR_W'(EVENT_ADDR));

  assign ctrl_we  = sel_ctrl  & {NUM_CH{we}};
  assign match_we = sel_match & {NUM_CH{we}};
  assign count_we = sel_count & {NUM_CH{we}};
  assign event_we = sel_event & we;

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel_ctrl[i])  rdata = ctrl_rd[i];
      if (sel_match[i]) rdata = match_rd[i];
      if (sel_count[i]) rdata = count_rd[i];
    end
    if (sel_event) rdata = event_rd;
  end

  // R10
  wr_strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_we, match_we, count_we, event_we}));
endmodule

// File: rtl/dmt_channel.sv
module dmt_channel
  import dmt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              match_we,
  input  logic              count_we,
  input  logic [CTRL_W-1:0] ctrl_val,
  input  logic [CNT_W-1:0]  wr_val,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CNT_W-1:0]  match_q,
  output logic [CNT_W-1:0]  count_q,
  output logic              hit
);
  logic run;
  assign run = ctrl_q[CTRL_CE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
    end else if (match_we) begin
      match_q <= wr_val;
    end
  end

  // software load wins over the running increment
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_we) begin
      count_q <= wr_val;
    end else if (run) begin
      count_q <= count_q + CNT_W'(1);
    end
  end

  assign hit = run && (count_q == match_q);

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !count_we) |=> $stable(count_q));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !count_we) |=> (count_q == $past(count_q) + CNT_W'(1)));

  // R3
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_we |=> (count_q == $past(wr_val)));
endmodule

// File: rtl/dmt_event.sv
module dmt_event #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hit,
  input  logic [NUM_CH-1:0] irq_en,
  input  logic              event_we,
  input  logic [NUM_CH-1:0] clr_mask,
  output logic [NUM_CH-1:0] event_q,
  output logic [NUM_CH-1:0] irq
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        event_q[i] <= 1'b0;
      end else if (hit[i]) begin
        event_q[i] <= 1'b1;
      end else if (event_we && clr_mask[i]) begin
        event_q[i] <= 1'b0;
      end
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> event_q[i]);

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (event_we && clr_mask[i] && !hit[i]) |=> !event_q[i]);

    // R7
    w0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (event_q[i] && !(event_we && clr_mask[i])) |=> event_q[i]);

    // R4
    rise_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(event_q[i]) |-> $past(hit[i]));
  end

  assign irq = event_q & irq_en;
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
  import dmt_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int unsigned CTRL_PAD = CNT_W - CTRL_W;
  localparam int unsigned EVT_PAD  = CNT_W - NUM_CH;

  logic [NUM_CH-1:0]             ctrl_we, match_we, count_we, hit, irq_en;
  logic                          event_we;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_q;
  logic [NUM_CH-1:0][CNT_W-1:0]  ctrl_rd, match_q, count_q;
  logic [NUM_CH-1:0]             event_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dmt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_we  (ctrl_we[i]),
      .match_we (match_we[i]),
      .count_we (count_we[i]),
      .ctrl_val (reg_wdata[CTRL_W-1:0]),
      .wr_val   (reg_wdata),
      .ctrl_q   (ctrl_q[i]),
      .match_q  (match_q[i]),
      .count_q  (count_q[i]),
      .hit      (hit[i])
    );
    assign ctrl_rd[i] = {{CTRL_PAD{1'b0}}, ctrl_q[i]};
    assign irq_en[i]  = ctrl_q[i][CTRL_IE];
  end

  dmt_regdec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(CNT_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (reg_addr),
    .we       (reg_we),
    .ctrl_rd  (ctrl_rd),
    .match_rd (match_q),
    .count_rd (count_q),
    .event_rd ({{EVT_PAD{1'b0}}, event_q}),
    .ctrl_we  (ctrl_we),
    .match_we (match_we),
    .count_we (count_we),
    .event_we (event_we),
    .rdata    (reg_rdata)
  );

  dmt_event #(.NUM_CH(NUM_CH)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .irq_en   (irq_en),
    .event_we (event_we),
    .clr_mask (reg_wdata[NUM_CH-1:0]),
    .event_q  (event_q),
    .irq      (irq)
  );

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> (event_q != '0));
endmodule

// File: tb/dual_match_timer_test.sv
module dual_match_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_CTRL0 = 8'h00, A_CTRL1 = 8'h04;
  localparam logic [7:0] A_MAT0 = 8'h18, A_MAT1 = 8'h1C;
  localparam logic [7:0] A_CNT0 = 8'h48, A_CNT1 = 8'h4C;
  localparam logic [7:0] A_EVT = 8'h60;

  always #2 clk = ~clk;

  dual_match_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTRL0, v); chk("R1 ctrl0", v, 0);
    rd(A_CTRL1, v); chk("R1 ctrl1", v, 0);
    rd(A_CNT0, v);  chk("R1 cnt0", v, 0);
    rd(A_MAT1, v);  chk("R1 match1", v, 0);
    rd(A_EVT, v);   chk("R1 event", v, 0);
    chk("R1 irq", {30'd0, irq}, 0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(A_CTRL0, 32'hFFFF_FFF2);
    rd(A_CTRL0, v); chk("R10 ctrl upper bits", v, 32'h2);
    wr(A_CTRL0, 32'h0);
    wr(A_MAT1, 32'hA5A5_1234);
    rd(A_MAT1, v); chk("R10 match1 readback", v, 32'hA5A5_1234);
    rd(8'h10, v);  chk("R10 unmapped 0x10", v, 0);
    rd(8'h64, v);  chk("R10 unmapped 0x64", v, 0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(A_CNT0, 32'd100);
    rd(A_CNT0, v); chk("R3 load", v, 32'd100);
    wr(A_CTRL0, 32'h1);
    rd(A_CNT0, v); chk("R2 first edge", v, 32'd100);
    repeat (4) @(negedge clk);
    rd(A_CNT0, v); chk("R2 four steps", v, 32'd104);
    wr(A_CTRL0, 32'h0);
    rd(A_CNT0, v); chk("R2 stop", v, 32'd106);
    repeat (3) @(negedge clk);
    rd(A_CNT0, v); chk("R2 hold", v, 32'd106);
    rd(A_CNT1, v); chk("R9 other counter", v, 0);
    rd(A_EVT, v);  chk("R9 no event", v, 0);
  endtask

  task automatic t_match();
    logic [31:0] v;
    wr(A_CNT0, 32'd0);
    wr(A_MAT0, 32'd5);
    wr(A_CTRL0, 32'h3);
    repeat (5) @(negedge clk);
    rd(A_EVT, v); chk("R4 not yet", v, 0);
    chk("R5 irq low before", {30'd0, irq}, 0);
    @(negedge clk);
    rd(A_EVT, v); chk("R4 event set", v, 32'h1);
    chk("R5 irq0 high", {30'd0, irq}, 32'h1);
    rd(A_CNT0, v); chk("R6 past match", v, 32'd6);
    wr(A_CTRL0, 32'h0);
    chk("R5 irq masked", {30'd0, irq}, 0);
    rd(A_EVT, v); chk("R5 event kept", v, 32'h1);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(A_CNT1, 32'hFFFF_FFFE);
    wr(A_MAT1, 32'hFFFF_FFFF);
    wr(A_CTRL1, 32'h1);
    repeat (3) @(negedge clk);
    rd(A_CNT1, v); chk("R6 wrap", v, 32'd1);
    rd(A_EVT, v);  chk("R9 both events", v, 32'h3);
    chk("R5 ie clear", {30'd0, irq}, 0);
    wr(A_CTRL1, 32'h3);
    chk("R5 irq1 high", {30'd0, irq}, 32'h2);
    wr(A_CTRL1, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(A_EVT, 32'h0);
    rd(A_EVT, v); chk("R7 zero write", v, 32'h3);
    wr(A_EVT, 32'h1);
    rd(A_EVT, v); chk("R7 clear bit0", v, 32'h2);
    wr(A_EVT, 32'hFFFF);
    rd(A_EVT, v); chk("R7 clear all", v, 0);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    wr(A_CNT1, 32'd0);
    wr(A_MAT1, 32'd3);
    wr(A_CTRL1, 32'h3);
    repeat (2) @(negedge clk);
    wr(A_EVT, 32'h2);
    rd(A_EVT, v); chk("R8 set wins", v, 32'h2);
    wr(A_CTRL1, 32'h0);
    wr(A_EVT, 32'h2);
    rd(A_EVT, v); chk("R8 later clear", v, 0);
  endtask

  task automatic t_idle_cmp();
    logic [31:0] v;
    wr(A_CNT0, 32'd7);
    wr(A_MAT0, 32'd7);
    repeat (5) @(negedge clk);
    rd(A_EVT, v);  chk("R11 no event", v, 0);
    rd(A_CNT0, v); chk("R11 held", v, 32'd7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_count();
    t_match();
    t_wrap();
    t_w1c();
    t_priority();
    t_idle_cmp();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule